// File: doc/BRIEF.md
# Shared Memory Bank Conflict Scheduler

This block takes one warp's shared-memory access and turns it into a short list of requests that a banked scratchpad can serve. A start strobe captures a byte address for each lane, a mask of active lanes and an atomic flag. Lanes that name the same 4-byte word are folded into one request whose lane bitmask lists every lane that shares it. Each request also gets an issue-order number. Requests with the same number fall in different banks, so a downstream arbiter may launch them in the same cycle.

The order number for a new request is the number of requests already placed on its bank. A word that several lanes read is a broadcast. It is moved to a fresh, unique order above the warp size, so it always occupies a cycle of its own. The warp can be split into equal parts that are handled one after another. Requests never merge across a part boundary, and a bank's running count is raised to the part's first lane index before it is used. This keeps a later part out of the cycles that an earlier part uses on the same bank.

When all lanes have been classified, the requests leave one per handshake over a valid/ready stream. They come out in ascending order number, and equal numbers keep the order in which the requests were created. A one-cycle done pulse follows the last record.

Top module: `shm_conflict_sched`

## Requirements
- R1: The bank of a lane is its word address (byte address shifted right by log2 of the word size, 4 bytes by default) taken modulo BANKS (32 by default). The record's word field carries that word address.
- R2: A lane whose bit in `active_mask` is 0 creates no request, sets no bit in any `out_mask`, and is never matched by another lane.
- R3: With `atomic` low, an active lane whose word equals the word of a request already created in the same part joins that request. Its bit (bit i for lane i) is set in that request's `out_mask`, and no new record is made for it.
- R4: With `atomic` high, every active lane gets its own record, and that record's `out_mask` has exactly one bit set.
- R5: A newly created request takes as its order the current count of requests on its bank. That count then increases by one.
- R6: Each time a lane joins an existing request, the request's order is replaced by the next value of a broadcast counter. The counter starts at LANES (32) and is incremented before each use, so the first join gives LANES+1. Any record with more than one mask bit therefore has an order above LANES.
- R7: The warp is divided into PARTS equal parts (2 by default, lanes 0-15 and 16-31). No record's mask spans two parts. Before a request is placed in part p, its bank count is raised to at least p*LANES/PARTS.
- R8: Records leave in non-decreasing order number. Records with equal order number leave in the order they were created, which is the order of the lowest lane in each mask.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the word, order and mask of the record do not change.
- R10: `done` is high for exactly one cycle, after the last record has been accepted. If no lane is active, `done` still pulses and no record is produced.
- R11: A `start` that arrives while a warp is being processed is ignored. The records produced are those of the warp already captured.
- R12: After reset, `out_valid` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Captures a new warp access when the block is idle |
| atomic | input | 1 | The access is atomic: no lane merging |
| active_mask | input | LANES | One bit per lane; 1 means the lane takes part |
| lane_addr | input | LANES*AW | Byte address of lane i in bits [i*AW +: AW] |
| out_valid | output | 1 | A request record is presented |
| out_ready | input | 1 | The consumer accepts the record this cycle |
| out_word | output | AW-log2(WORD_BYTES) | Word address of the request |
| out_order | output | log2(2*LANES) | Issue-order number of the request |
| out_mask | output | LANES | Lanes served by the request |
| done | output | 1 | One-cycle pulse after the last record |

## Verification
Several properties are checked on every cycle. A stalled record is held stable. `done` is a single pulse. Atomic records have one lane. Multi-lane records carry a broadcast order above LANES. No mask leaves its part or names an inactive lane. Accepted orders never decrease. A start that arrives while the block is busy leaves the captured mask untouched. Only the bench's scenarios can show that each record has the right word, the exact order number and the exact membership, including the bank-count raise at the part boundary and the tie order between requests. It checks these against a reference model over directed conflict patterns and seeded random warps.

// File: rtl/shm_sched_pkg.sv
package shm_sched_pkg;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_BUILD = 2'd1,
    S_EMIT  = 2'd2
  } sched_state_e;

  // first lane index of the part that holds a given lane
  function automatic int unsigned part_first_lane(input int unsigned lane,
                                                  input int unsigned part_len);
    return lane - (lane % part_len);
  endfunction

endpackage

// File: rtl/shm_req_table.sv
module shm_req_table
  import shm_sched_pkg::*;
#(
  parameter int LANES    = 32,
  parameter int BANKS    = 32,
  parameter int WW       = 30,
  parameter int PART_LEN = 16,
  parameter int ORDW     = 6,
  parameter int IDXW     = 5,
  parameter int CNTW     = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear,
  input  logic                       step,
  input  logic [IDXW-1:0]            lane_idx,
  input  logic                       lane_act,
  input  logic [WW-1:0]              lane_word,
  input  logic                       atomic,
  output logic [LANES-1:0][WW-1:0]   ent_word,
  output logic [LANES-1:0][ORDW-1:0] ent_ord,
  output logic [LANES-1:0][LANES-1:0] ent_mask,
  output logic [CNTW-1:0]            ent_cnt
);

  localparam int BW = $clog2(BANKS);

  function automatic logic [BW-1:0] bank_of(input logic [WW-1:0] w);
    return w[BW-1:0];
  endfunction

  logic [BANKS-1:0][ORDW-1:0] bank_cnt;
  logic [ORDW-1:0]            bcast;
  logic [CNTW-1:0]            part_base;

  logic            part_first;
  logic [CNTW-1:0] base_now;
  logic [BW-1:0]   bank;
  logic [ORDW-1:0] part_start;
  logic [ORDW-1:0] raised;
  logic [ORDW-1:0] bcast_next;
  logic            hit;
  logic [IDXW-1:0] hit_idx;
  logic            new_req;
  logic            join_req;

  always_comb begin
    part_first = (int'(lane_idx) % PART_LEN) == 0;
    base_now   = part_first ? ent_cnt : part_base;
    bank       = bank_of(lane_word);
    part_start = ORDW'(part_first_lane(int'(lane_idx), PART_LEN));
    raised     = (bank_cnt[bank] < part_start) ? part_start : bank_cnt[bank];
    bcast_next = bcast + ORDW'(1);
    hit        = 1'b0;
    hit_idx    = '0;
    for (int j = 0; j < LANES; j++) begin
      if (!hit && !atomic && CNTW'(j) >= base_now && CNTW'(j) < ent_cnt &&
          ent_word[j] == lane_word) begin
        hit     = 1'b1;
        hit_idx = IDXW'(j);
      end
    end
    new_req  = step && lane_act && !hit;
    join_req = step && lane_act && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_cnt   <= '0;
      bank_cnt  <= '0;
      bcast     <= ORDW'(LANES);
      part_base <= '0;
      ent_word  <= '0;
      ent_ord   <= '0;
      ent_mask  <= '0;
    end else if (clear) begin
      ent_cnt   <= '0;
      bank_cnt  <= '0;
      bcast     <= ORDW'(LANES);
      part_base <= '0;
      ent_mask  <= '0;
    end else if (step) begin
      if (part_first) part_base <= ent_cnt;
      if (new_req) begin
        ent_word[ent_cnt[IDXW-1:0]] <= lane_word;
        ent_ord[ent_cnt[IDXW-1:0]]  <= raised;
        ent_mask[ent_cnt[IDXW-1:0]] <= LANES'(1) << lane_idx;
        bank_cnt[bank]              <= raised + ORDW'(1);
        ent_cnt                     <= ent_cnt + CNTW'(1);
      end
      if (join_req) begin
        ent_mask[hit_idx][lane_idx] <= 1'b1;
        ent_ord[hit_idx]            <= bcast_next;
        bcast                       <= bcast_next;
      end
    end
  end

  // R3: at most one request per lane already seen
  p_cnt_le_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> (ent_cnt <= CNTW'(lane_idx)));

  // R7: a bank used in a later part is at least the part start after placement
  p_part_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    new_req && !clear |=> bank_cnt[$past(bank)] > $past(part_start));

endmodule

// File: rtl/shm_req_pick.sv
module shm_req_pick #(
  parameter int LANES = 32,
  parameter int ORDW  = 6,
  parameter int IDXW  = 5,
  parameter int CNTW  = 6
) (
  input  logic [LANES-1:0][ORDW-1:0] ent_ord,
  input  logic [CNTW-1:0]            ent_cnt,
  input  logic [LANES-1:0]           sent,
  output logic                       any,
  output logic [IDXW-1:0]            sel
);

  logic [ORDW-1:0] best;

  // strict less-than keeps the lowest index among equal orders
  always_comb begin
    any  = 1'b0;
    sel  = '0;
    best = '0;
    for (int j = 0; j < LANES; j++) begin
      if (CNTW'(j) < ent_cnt && !sent[j] && (!any || ent_ord[j] < best)) begin
        any  = 1'b1;
        sel  = IDXW'(j);
        best = ent_ord[j];
      end
    end
  end

endmodule

// File: rtl/shm_conflict_sched.sv
module shm_conflict_sched
  import shm_sched_pkg::*;
#(
  parameter int LANES      = 32,
  parameter int BANKS      = 32,
  parameter int WORD_BYTES = 4,
  parameter int AW         = 32,
  parameter int PARTS      = 2,
  localparam int WSH       = $clog2(WORD_BYTES),
  localparam int WW        = AW - WSH,
  localparam int ORDW      = $clog2(2 * LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                atomic,
  input  logic [LANES-1:0]    active_mask,
  input  logic [LANES*AW-1:0] lane_addr,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [WW-1:0]       out_word,
  output logic [ORDW-1:0]     out_order,
  output logic [LANES-1:0]    out_mask,
  output logic                done
);

  localparam int IDXW     = $clog2(LANES);
  localparam int CNTW     = $clog2(LANES + 1);
  localparam int PART_LEN = LANES / PARTS;

  function automatic logic [WW-1:0] word_of(input logic [AW-1:0] a);
    return a[AW-1:WSH];
  endfunction

  function automatic logic within_one_part(input logic [LANES-1:0] m);
    logic ok;
    logic [LANES-1:0] pm;
    ok = 1'b0;
    for (int p = 0; p < PARTS; p++) begin
      pm = '0;
      for (int b = 0; b < PART_LEN; b++) pm[p*PART_LEN + b] = 1'b1;
      if ((m & ~pm) == '0) ok = 1'b1;
    end
    return ok;
  endfunction

  sched_state_e           state;
  logic [IDXW-1:0]        lane_idx;
  logic [LANES-1:0]       mask_q;
  logic [LANES-1:0][WW-1:0] word_q;
  logic                   atom_q;
  logic [LANES-1:0]       sent;

  logic                   start_acc;
  logic                   step;
  logic                   out_fire;
  logic                   any;
  logic [IDXW-1:0]        sel;

  logic [LANES-1:0][WW-1:0]    ent_word;
  logic [LANES-1:0][ORDW-1:0]  ent_ord;
  logic [LANES-1:0][LANES-1:0] ent_mask;
  logic [CNTW-1:0]             ent_cnt;

  logic unused_low_bits;
  always_comb begin
    unused_low_bits = 1'b0;
    for (int i = 0; i < LANES; i++)
      unused_low_bits = unused_low_bits ^ (^lane_addr[i*AW +: WSH]);
  end

  assign start_acc = start && (state == S_IDLE);
  assign step      = (state == S_BUILD);
  assign out_valid = (state == S_EMIT) && any;
  assign done      = (state == S_EMIT) && !any;
  assign out_fire  = out_valid && out_ready;
  assign out_word  = ent_word[sel];
  assign out_order = ent_ord[sel];
  assign out_mask  = ent_mask[sel];

  shm_req_table #(
    .LANES(LANES), .BANKS(BANKS), .WW(WW), .PART_LEN(PART_LEN),
    .ORDW(ORDW), .IDXW(IDXW), .CNTW(CNTW)
  ) i_table (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .step(step),
    .lane_idx(lane_idx), .lane_act(mask_q[lane_idx]),
    .lane_word(word_q[lane_idx]), .atomic(atom_q),
    .ent_word(ent_word), .ent_ord(ent_ord), .ent_mask(ent_mask),
    .ent_cnt(ent_cnt)
  );

  shm_req_pick #(
    .LANES(LANES), .ORDW(ORDW), .IDXW(IDXW), .CNTW(CNTW)
  ) i_pick (
    .ent_ord(ent_ord), .ent_cnt(ent_cnt), .sent(sent),
    .any(any), .sel(sel)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      lane_idx <= '0;
      mask_q   <= '0;
      word_q   <= '0;
      atom_q   <= 1'b0;
      sent     <= '0;
    end else begin
      case (state)
        S_IDLE: if (start_acc) begin
          mask_q   <= active_mask;
          atom_q   <= atomic;
          lane_idx <= '0;
          sent     <= '0;
          for (int i = 0; i < LANES; i++)
            word_q[i] <= word_of(lane_addr[i*AW +: AW]);
          state    <= S_BUILD;
        end
        S_BUILD: begin
          lane_idx <= lane_idx + IDXW'(1);
          if (lane_idx == IDXW'(LANES - 1)) state <= S_EMIT;
        end
        S_EMIT: begin
          if (out_fire) sent[sel] <= 1'b1;
          if (!any) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // ordering history kept for the sort check
  logic [ORDW-1:0] prev_ord;
  logic            have_prev;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_ord  <= '0;
      have_prev <= 1'b0;
    end else if (start_acc) begin
      have_prev <= 1'b0;
    end else if (out_fire) begin
      prev_ord  <= out_order;
      have_prev <= 1'b1;
    end
  end

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !done);

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word) &&
                                $stable(out_order) && $stable(out_mask));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !out_valid);

  p_atomic_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && atom_q |-> $countones(out_mask) == 1);

  p_bcast_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $countones(out_mask) > 1 |-> out_order > ORDW'(LANES));

  p_active_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_mask & ~mask_q) == '0);

  p_one_part_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> within_one_part(out_mask));

  p_sorted_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_fire && have_prev |-> out_order >= prev_ord);

  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state != S_IDLE |=> $stable(mask_q) && $stable(atom_q));

endmodule

// File: tb/test_shm_conflict_sched.sv
module test_shm_conflict_sched;

  localparam int CLK_PERIOD = 10;
  localparam int L  = 32;
  localparam int NB = 32;
  localparam int PL = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          atomic = 1'b0;
  logic [L-1:0]  active_mask = '0;
  logic [L*32-1:0] lane_addr = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [29:0]   out_word;
  logic [5:0]    out_order;
  logic [L-1:0]  out_mask;
  logic          done;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shm_conflict_sched i_shm_conflict_sched (
    .clk(clk), .rst_n(rst_n), .start(start), .atomic(atomic),
    .active_mask(active_mask), .lane_addr(lane_addr),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_order(out_order), .out_mask(out_mask), .done(done)
  );

  logic [31:0]  st_addr [L];
  logic [L-1:0] st_mask;
  logic         st_atom;

  int           e_n;
  logic [29:0]  e_w [L];
  int           e_o [L];
  logic [L-1:0] e_m [L];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint got, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  // reference: classify lanes part by part, then stable sort by order
  task automatic ref_model();
    int bank_use [NB];
    int bc;
    for (int b = 0; b < NB; b++) bank_use[b] = 0;
    bc  = L;
    e_n = 0;
    for (int p = 0; p < L / PL; p++) begin
      int first_ent;
      first_ent = e_n;
      for (int ln = p * PL; ln < (p + 1) * PL; ln++) begin
        if (st_mask[ln]) begin
          logic [29:0] w;
          int found;
          w = st_addr[ln][31:2];
          found = -1;
          if (!st_atom)
            for (int k = first_ent; k < e_n; k++)
              if (found < 0 && e_w[k] == w) found = k;
          if (found >= 0) begin
            e_m[found][ln] = 1'b1;
            bc = bc + 1;
            e_o[found] = bc;
          end else begin
            int bk;
            bk = int'(w % NB);
            if (bank_use[bk] < p * PL) bank_use[bk] = p * PL;
            e_w[e_n] = w;
            e_o[e_n] = bank_use[bk];
            e_m[e_n] = L'(1) << ln;
            bank_use[bk] = bank_use[bk] + 1;
            e_n = e_n + 1;
          end
        end
      end
    end
    for (int i = 1; i < e_n; i++) begin
      int j;
      logic [29:0] tw;
      int to;
      logic [L-1:0] tm;
      tw = e_w[i]; to = e_o[i]; tm = e_m[i];
      j = i - 1;
      while (j >= 0 && e_o[j] > to) begin
        e_w[j+1] = e_w[j]; e_o[j+1] = e_o[j]; e_m[j+1] = e_m[j];
        j = j - 1;
      end
      e_w[j+1] = tw; e_o[j+1] = to; e_m[j+1] = tm;
    end
  endtask

  task automatic run_case(input bit poke_busy);
    int got;
    int cyc;
    bit done_seen;
    bit stalled;
    logic [29:0] s_w;
    logic [5:0]  s_o;
    logic [L-1:0] s_m;
    ref_model();
    @(negedge clk);
    for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = st_addr[i];
    active_mask = st_mask;
    atomic = st_atom;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R11: a second start while busy with different data
      @(negedge clk);
      for (int i = 0; i < L; i++) lane_addr[i*32 +: 32] = 32'h40 + 32'(i) * 4;
      active_mask = ~st_mask;
      atomic = ~st_atom;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    got = 0; cyc = 0; done_seen = 1'b0; stalled = 1'b0;
    s_w = '0; s_o = '0; s_m = '0;
    while (!done_seen && cyc < 3000) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #1;
      if (stalled) begin
        chk(out_valid && out_word == s_w && out_order == s_o && out_mask == s_m,
            "R9", "stalled record held", longint'(out_order), longint'(s_o));
        stalled = 1'b0;
      end
      if (out_valid) begin
        if (out_ready) begin
          if (got < e_n) begin
            chk(out_word == e_w[got], "R1/R3", "word", out_word, e_w[got]);
            chk(int'(out_order) == e_o[got], "R5/R6/R7/R8", "order",
                out_order, e_o[got]);
            chk(out_mask == e_m[got], "R2/R3/R4", "mask", out_mask, e_m[got]);
          end else begin
            chk(1'b0, "R10", "extra record", got + 1, e_n);
          end
          got++;
        end else begin
          stalled = 1'b1;
          s_w = out_word; s_o = out_order; s_m = out_mask;
        end
      end
      if (done) done_seen = 1'b1;
      cyc++;
    end
    chk(done_seen, "R10", "done seen", done_seen, 1);
    chk(got == e_n, "R10", "record count", got, e_n);
    // after done: one-cycle pulse, then quiet (R10, R11)
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      #1;
      if (out_valid || done) begin
        chk(1'b0, "R10/R11", "activity after done", 1, 0);
        break;
      end
    end
    out_ready = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(!out_valid && !done, "R12", "quiet in reset", {out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(!out_valid && !done, "R12", "quiet after reset", {out_valid, done}, 0);

    // R3/R6/R7: whole warp on one word -> one broadcast per part
    for (int i = 0; i < L; i++) st_addr[i] = 32'h1000;
    st_mask = '1; st_atom = 1'b0;
    run_case(1'b0);
    chk(e_n == 2 && e_o[0] == 47 && e_o[1] == 62, "R6", "reference broadcast orders",
        e_o[0], 47);

    // R4: same, atomic -> 32 single-lane records, orders 0..31
    st_atom = 1'b1;
    run_case(1'b0);

    // R1/R5/R7: distinct banks -> order 0 in part 0, order 16 in part 1
    for (int i = 0; i < L; i++) st_addr[i] = 32'(i) * 4 + 32'h200;
    st_atom = 1'b0;
    run_case(1'b0);

    // R5: all lanes on bank 0, different words -> orders 0..31
    for (int i = 0; i < L; i++) st_addr[i] = 32'(i) * NB * 4;
    run_case(1'b0);

    // R2/R10: no active lane -> no record, done still pulses
    st_mask = '0;
    run_case(1'b0);

    // R2: alternate lanes inactive on a shared word
    for (int i = 0; i < L; i++) st_addr[i] = 32'h80;
    st_mask = 32'h5555_0001;
    run_case(1'b0);

    // R11: start while busy is ignored
    for (int i = 0; i < L; i++) st_addr[i] = 32'(i % 5) * 36;
    st_mask = 32'hF0F0_3C3C;
    run_case(1'b1);

    // seeded random warps
    for (int t = 0; t < 40; t++) begin
      for (int i = 0; i < L; i++)
        st_addr[i] = (($urandom % 2) != 0) ? 32'($urandom % 8) * 4
                                          : 32'($urandom % 6) * NB * 4 + 32'($urandom % 4);
      st_mask = $urandom;
      st_atom = ($urandom % 5) == 0;
      run_case(($urandom % 6) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule